// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers data bytes destined for one page of a byte-addressed nonvolatile array and hands them to the array in a single write. A transaction opens with a start strobe that carries a full byte address. The upper address bits pick the page and the lower bits pick where the first byte lands. Every accepted byte strobe stores one byte at the current in-page offset and advances that offset. The offset wraps inside the page, so a long burst overwrites the bytes it loaded first.

Nothing reaches the array while bytes are loading. When the commit strobe arrives (raised by the bus front end at a stop condition), the block issues one page-wide write with a byte enable for every byte loaded in this transaction. It then reports busy for a fixed number of clock cycles that stands for the programming time. While busy it ignores loads, starts and commits. An abort input (a repeated start, or a rejection by write protection) throws the collected bytes away. A commit that finds no loaded bytes does nothing.

With the default parameters the block serves a 64 KiB array of 512 pages of 128 bytes each.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, busy and mem_wr_en are 0.
- R2: An accepted ld_start takes the page from ld_addr[ADDR_W-1:PAGE_W] and the starting offset from ld_addr[PAGE_W-1:0]. Each accepted ld_byte stores ld_data at the current offset, and the offset then increments by one. A byte strobe in the same cycle as ld_start is stored at the new start offset.
- R3: The offset wraps from 2**PAGE_W-1 to 0 without changing the page, so a later byte replaces an earlier byte at the same offset.
- R4: mem_wr_en stays 0 while bytes are loading. It is raised only in the cycle after an accepted commit.
- R5: An accepted commit (commit=1, abort=0, busy=0, at least one byte loaded) drives mem_wr_en high for exactly one cycle. In that cycle mem_page is the page, mem_wdata byte k (bits 8k+7:8k) is the last byte loaded at offset k, and mem_be bit k is 1 exactly for the offsets loaded in this transaction. All other bytes of the array keep their contents.
- R6: busy rises in the same cycle as mem_wr_en and stays high for exactly CYCLE_CNT cycles.
- R7: While busy is 1, ld_start, ld_byte and commit are ignored. Bytes presented then are never written. A byte strobe in the commit cycle is also discarded.
- R8: abort discards all loaded bytes without a write or busy period. It overrides a commit in the same cycle.
- R9: A commit with no loaded bytes produces no write and leaves busy at 0.
- R10: An accepted commit or a new ld_start ends the transaction, so a later commit without new bytes writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_start | input | 1 | Opens a transaction at ld_addr |
| ld_addr | input | ADDR_W | Start byte address |
| ld_byte | input | 1 | Byte strobe |
| ld_data | input | DATA_W | Byte to load |
| commit | input | 1 | Commit strobe, raised at bus stop |
| abort | input | 1 | Discard the transaction |
| busy | output | 1 | Write cycle in progress |
| mem_wr_en | output | 1 | One-cycle page write to the array |
| mem_page | output | ADDR_W-PAGE_W | Page written |
| mem_wdata | output | DATA_W*2**PAGE_W | Page data, byte k at bits 8k+7:8k |
| mem_be | output | 2**PAGE_W | Byte enables, bit k for offset k |

## Verification
The bench builds the block with ADDR_W=6, PAGE_W=3 and CYCLE_CNT=4. That gives 8 pages of 8 bytes and a short write cycle. Every page is swept with every start offset and burst lengths of 1, 3, 8 and 11 bytes, so the wrap and the overwrite of early bytes happen on every offset. All 64 bytes of a bench-side array model are compared after each commit. With so small a configuration the abort, empty-commit and ignored-while-busy cases can be exercised directly and the whole array checked after each.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   typedef enum logic {
      PCB_IDLE  = 1'b0,
      PCB_CYCLE = 1'b1
   } pcb_state_e;
endpackage

// File: rtl/pcb_addr_track.sv
module pcb_addr_track #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 7,
   localparam int PG_W  = ADDR_W - PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              take_i,
   output logic [PG_W-1:0]   page_o,
   output logic [PAGE_W-1:0] off_o
);
   logic [PAGE_W-1:0] off_q;
   logic [PG_W-1:0]   page_q;

   // Offset used by a byte taken in this cycle.
   assign off_o  = start_i ? addr_i[PAGE_W-1:0] : off_q;
   assign page_o = page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= '0;
         page_q <= '0;
      end else begin
         if (start_i) page_q <= addr_i[ADDR_W-1:PAGE_W];
         if (take_i)
            off_q <= off_o + 1'b1;
         else if (start_i)
            off_q <= addr_i[PAGE_W-1:0];
      end
   end

   // R3: the offset wraps to zero and keeps the page
   a_r3_offset_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !start_i && off_q == {PAGE_W{1'b1}}) |=> (off_q == '0 && $stable(page_q)));
endmodule

// File: rtl/pcb_entry_bank.sv
module pcb_entry_bank #(
   parameter int PAGE_W = 7,
   parameter int DATA_W = 8,
   localparam int NBYTES = 1 << PAGE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take_i,
   input  logic [PAGE_W-1:0]        off_i,
   input  logic [DATA_W-1:0]        data_i,
   input  logic                     clear_i,
   output logic [NBYTES*DATA_W-1:0] data_o,
   output logic [NBYTES-1:0]        vld_o
);
   for (genvar e = 0; e < NBYTES; e++) begin : g_entry
      logic              hit;
      logic [DATA_W-1:0] byte_q;
      logic              vld_q;

      assign hit = take_i && (off_i == PAGE_W'(e));

      always_ff @(posedge clk) begin
         if (hit) byte_q <= data_i;
      end

      // A take in a clearing cycle (start with byte) opens the new set.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld_q <= 1'b0;
         else if (clear_i) vld_q <= hit;
         else if (hit)     vld_q <= 1'b1;
      end

      assign data_o[e*DATA_W +: DATA_W] = byte_q;
      assign vld_o[e]                   = vld_q;
   end
endmodule

// File: rtl/pcb_cycle_timer.sv
module pcb_cycle_timer
   import pcb_pkg::*;
#(
   parameter int CYCLE_CNT = 500000,
   localparam int CNT_W    = (CYCLE_CNT > 1) ? $clog2(CYCLE_CNT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   output logic busy_o
);
   pcb_state_e state_q;

   assign busy_o = (state_q == PCB_CYCLE);

   if (CYCLE_CNT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) state_q <= PCB_IDLE;
         else        state_q <= launch_i ? PCB_CYCLE : PCB_IDLE;
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q <= PCB_IDLE;
            cnt_q   <= '0;
         end else if (state_q == PCB_IDLE) begin
            if (launch_i) begin
               state_q <= PCB_CYCLE;
               cnt_q   <= CNT_W'(CYCLE_CNT - 1);
            end
         end else if (cnt_q == '0) begin
            state_q <= PCB_IDLE;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      // R6: the counter starts at the top and falls one per busy cycle
      a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_o && cnt_q != '0) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));
   end
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 7,
   parameter int DATA_W    = 8,
   parameter int CYCLE_CNT = 500000,
   localparam int PG_W     = ADDR_W - PAGE_W,
   localparam int NBYTES   = 1 << PAGE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_start,
   input  logic [ADDR_W-1:0]        ld_addr,
   input  logic                     ld_byte,
   input  logic [DATA_W-1:0]        ld_data,
   input  logic                     commit,
   input  logic                     abort,
   output logic                     busy,
   output logic                     mem_wr_en,
   output logic [PG_W-1:0]          mem_page,
   output logic [NBYTES*DATA_W-1:0] mem_wdata,
   output logic [NBYTES-1:0]        mem_be
);
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("PAGE_W must lie between 1 and ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (CYCLE_CNT < 1) begin : g_bad_cycle
      $error("CYCLE_CNT must be at least 1");
   end

   logic                     accept;
   logic                     take;
   logic                     start_ok;
   logic                     go;
   logic                     clear;
   logic [PG_W-1:0]          page;
   logic [PAGE_W-1:0]        off;
   logic [NBYTES*DATA_W-1:0] bank_data;
   logic [NBYTES-1:0]        vld;

   // Loads are accepted only when idle and not ending the transaction.
   assign accept   = !busy && !abort && !commit;
   assign take     = ld_byte && accept;
   assign start_ok = ld_start && accept;
   assign go       = commit && !abort && !busy && (|vld);
   assign clear    = abort || go || start_ok;

   pcb_addr_track #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_ok),
      .addr_i (ld_addr),
      .take_i (take),
      .page_o (page),
      .off_o  (off)
   );

   pcb_entry_bank #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) i_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .off_i  (off),
      .data_i (ld_data),
      .clear_i(clear),
      .data_o (bank_data),
      .vld_o  (vld)
   );

   pcb_cycle_timer #(.CYCLE_CNT(CYCLE_CNT)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch_i(go),
      .busy_o  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_wr_en <= 1'b0;
         mem_page  <= '0;
         mem_be    <= '0;
      end else begin
         mem_wr_en <= go;
         if (go) begin
            mem_page <= page;
            mem_be   <= vld;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (go) mem_wdata <= bank_data;
   end

   // R5: a write lasts a single cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !mem_wr_en);
   // R4: a write only follows a commit strobe
   a_r4_write_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($past(commit) && !$past(abort)));
   // R6: busy covers the write cycle
   a_r6_busy_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> busy);
   // R5: enables never empty on a write
   a_r5_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_be != '0));
   // R7: loaded set frozen while busy
   a_r7_busy_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vld));
   // R8: abort empties the set
   a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (vld == '0 && !mem_wr_en));
   // R9: empty commit starts nothing
   a_r9_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !busy && vld == '0) |=> (!busy && !mem_wr_en));
endmodule

// File: tb/test_page_commit_buffer.sv
module test_page_commit_buffer;
   localparam int ADDR_W = 6;
   localparam int PAGE_W = 3;
   localparam int DATA_W = 8;
   localparam int CYC    = 4;
   localparam int NB     = 1 << PAGE_W;
   localparam int NPG    = 1 << (ADDR_W - PAGE_W);
   localparam int MEMSZ  = 1 << ADDR_W;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 ld_start = 1'b0;
   logic [ADDR_W-1:0]    ld_addr = '0;
   logic                 ld_byte = 1'b0;
   logic [DATA_W-1:0]    ld_data = '0;
   logic                 commit = 1'b0;
   logic                 abort = 1'b0;
   logic                 busy;
   logic                 mem_wr_en;
   logic [ADDR_W-PAGE_W-1:0] mem_page;
   logic [NB*DATA_W-1:0] mem_wdata;
   logic [NB-1:0]        mem_be;

   int errors = 0;
   int checks = 0;
   int pulses = 0;
   logic [7:0] arr [MEMSZ];
   logic [7:0] expm [MEMSZ];

   always #5 clk = ~clk;

   page_commit_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                        .CYCLE_CNT(CYC)) i_page_commit_buffer (
      .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
      .ld_byte(ld_byte), .ld_data(ld_data), .commit(commit), .abort(abort),
      .busy(busy), .mem_wr_en(mem_wr_en), .mem_page(mem_page),
      .mem_wdata(mem_wdata), .mem_be(mem_be));

   // Array model fed by the write port.
   always @(posedge clk) begin
      if (mem_wr_en) begin
         pulses++;
         for (int b = 0; b < NB; b++)
            if (mem_be[b]) arr[int'(mem_page)*NB + b] = mem_wdata[b*8 +: 8];
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cmp_array(input string req);
      int bad = 0;
      for (int a = 0; a < MEMSZ; a++) if (arr[a] !== expm[a]) bad++;
      check(bad == 0, req, bad, 0);
   endtask

   task automatic start_at(input int pg, input int off);
      @(negedge clk);
      ld_start = 1'b1; ld_addr = ADDR_W'(pg*NB + off);
      @(negedge clk);
      ld_start = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] d);
      @(negedge clk);
      ld_byte = 1'b1; ld_data = d;
      @(negedge clk);
      ld_byte = 1'b0;
   endtask

   // Commit and measure the busy window; returns the busy length.
   task automatic do_commit(output int blen);
      @(negedge clk);
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
      blen = 0;
      while (busy && blen < 100) begin
         blen++;
         @(negedge clk);
      end
   endtask

   function automatic logic [7:0] pat(input int pg, input int off, input int n, input int i);
      return 8'((pg*37 + off*11 + n*5 + i*3 + 1) & 255);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int blen;
      int p0;
      int lens [4] = '{1, 3, 8, 11};
      for (int a = 0; a < MEMSZ; a++) begin arr[a] = 8'hFF; expm[a] = 8'hFF; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0, "R1 busy", int'(busy), 0);
      check(mem_wr_en == 1'b0, "R1 mem_wr_en", int'(mem_wr_en), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: empty commit at idle
      p0 = pulses;
      do_commit(blen);
      check(blen == 0, "R9 busy on empty commit", blen, 0);
      check(pulses == p0, "R9 write on empty commit", pulses - p0, 0);

      // R2 R3 R4 R5 R6 sweep
      for (int pg = 0; pg < NPG; pg++)
         for (int off = 0; off < NB; off++)
            for (int k = 0; k < 4; k++) begin
               int n = lens[k];
               p0 = pulses;
               start_at(pg, off);
               for (int i = 0; i < n; i++) begin
                  put_byte(pat(pg, off, n, i));
                  expm[pg*NB + (off + i) % NB] = pat(pg, off, n, i);
               end
               check(pulses == p0, "R4 no write while loading", pulses - p0, 0);
               do_commit(blen);
               check(blen == CYC, "R6 busy length", blen, CYC);
               check(pulses == p0 + 1, "R5 one write", pulses - p0, 1);
               cmp_array("R2 R3 R5 array contents");
            end

      // R10: start with byte in the same cycle, then another byte
      @(negedge clk);
      ld_start = 1'b1; ld_addr = ADDR_W'(2*NB + 5); ld_byte = 1'b1; ld_data = 8'hA5;
      @(negedge clk);
      ld_start = 1'b0; ld_byte = 1'b0;
      put_byte(8'h5A);
      expm[2*NB + 5] = 8'hA5; expm[2*NB + 6] = 8'h5A;
      do_commit(blen);
      cmp_array("R2 start with byte");
      // R10: commit again without bytes writes nothing
      p0 = pulses;
      do_commit(blen);
      check(pulses == p0, "R10 second commit", pulses - p0, 0);
      check(blen == 0, "R10 second commit busy", blen, 0);

      // R10: a new start drops the earlier bytes
      start_at(4, 1);
      put_byte(8'h11);
      start_at(4, 3);
      put_byte(8'h22);
      expm[4*NB + 3] = 8'h22;
      do_commit(blen);
      cmp_array("R10 restart drops bytes");

      // R8: abort discards, later commit writes nothing
      p0 = pulses;
      start_at(1, 0);
      put_byte(8'h33); put_byte(8'h44);
      @(negedge clk); abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      do_commit(blen);
      check(pulses == p0, "R8 abort then commit", pulses - p0, 0);
      check(blen == 0, "R8 abort busy", blen, 0);
      cmp_array("R8 array after abort");

      // R8: abort together with commit
      start_at(1, 2);
      put_byte(8'h55);
      @(negedge clk); abort = 1'b1; commit = 1'b1;
      @(negedge clk); abort = 1'b0; commit = 1'b0;
      check(busy == 1'b0, "R8 abort overrides commit", int'(busy), 0);
      check(pulses == p0, "R8 abort overrides write", pulses - p0, 0);

      // R7: loads, starts and commits during busy are ignored
      start_at(6, 0);
      put_byte(8'h66);
      expm[6*NB] = 8'h66;
      @(negedge clk); commit = 1'b1;
      @(negedge clk); commit = 1'b0;
      ld_start = 1'b1; ld_addr = ADDR_W'(7*NB); ld_byte = 1'b1; ld_data = 8'h77;
      @(negedge clk); ld_start = 1'b0;
      @(negedge clk); commit = 1'b1;
      @(negedge clk); commit = 1'b0; ld_byte = 1'b0;
      while (busy) @(negedge clk);
      p0 = pulses;
      do_commit(blen);
      check(pulses == p0, "R7 bytes during busy", pulses - p0, 0);
      cmp_array("R7 array after busy loads");

      // R7: byte strobe in the commit cycle is discarded
      start_at(3, 4);
      put_byte(8'h88);
      expm[3*NB + 4] = 8'h88;
      @(negedge clk); commit = 1'b1; ld_byte = 1'b1; ld_data = 8'h99;
      @(negedge clk); commit = 1'b0; ld_byte = 1'b0;
      while (busy) @(negedge clk);
      p0 = pulses;
      do_commit(blen);
      check(pulses == p0, "R7 byte in commit cycle", pulses - p0, 0);
      cmp_array("R7 array after commit-cycle byte");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule